// File: doc/BRIEF.md
# Acceleration Sensor Status Flag Manager

This block holds the two status flags that a three-axis acceleration sensor reports in every serial response frame and in its interrupt-status register. One flag is the self-test flag. It has two separate causes, and each cause is cleared in its own way. The other flag is the saturation flag. It latches whenever any axis magnitude goes past that axis's limit. It stays latched until software reads the interrupt-status register. While it is latched, the acceleration data on every channel is marked invalid.

The block takes three signed 16-bit samples together with a valid strobe. It also takes a checksum-result pulse with a pass/fail flag, two self-test alarm levels (continuous and static), and a one-cycle strobe that marks a read of the interrupt-status register. The scale is 1 g = 1000 LSB. Two axes have a limit of 2270 LSB. One axis, selected by a parameter and z by default, has twice that limit: 4540 LSB. The frame shifter and the checksum engine sit outside this block. They use the flag outputs directly.

Top module: `accel_status_flags`

## Requirements
- R1: While reset is asserted, and after it is released, `st_flag` and `sat_flag` are 0 and `data_ok` is 1. No flag changes until stimulus arrives.
- R2: A checksum-result pulse with `chk_pass`=0 sets `st_flag` on the next clock edge.
- R3: An ST set by a checksum failure is not cleared by a status read. It is cleared only by a later checksum-result pulse with `chk_pass`=1, and only if no alarm cause is also pending.
- R4: Either alarm input (`alarm_cont` or `alarm_static`) at 1 sets `st_flag` on the next edge. This alarm cause stays latched after the alarm input drops. A status read clears it, provided no alarm input is 1 in that same cycle.
- R5: A valid sample with |x| > 2270 or |y| > 2270 sets `sat_flag` on the next edge. A magnitude of exactly 2270 does not set it. Negative samples are compared by their magnitude.
- R6: The z axis sets `sat_flag` only when |z| > 4540. Values from 2271 to 4540 do not set it. The most negative sample, -32768, does set it.
- R7: `sat_flag` stays at 1 after the excess ends. A status read with no excess in the same cycle clears it on the next edge.
- R8: When a set condition and a status read happen in the same cycle, the set wins. This holds for SAT and for the alarm cause of ST.
- R9: `data_ok` is the inverse of `sat_flag` at all times.
- R10: Sample values are ignored while `smp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | Sample strobe for the three axis inputs |
| smp_x | input | 16 | Signed x sample, 1000 LSB per g |
| smp_y | input | 16 | Signed y sample |
| smp_z | input | 16 | Signed z sample |
| chk_done | input | 1 | One-cycle pulse: a checksum check has finished |
| chk_pass | input | 1 | Result of that check, 1 = pass, qualified by chk_done |
| alarm_cont | input | 1 | Continuous self-test alarm level |
| alarm_static | input | 1 | Static self-test alarm level |
| status_rd | input | 1 | One-cycle pulse: the interrupt-status register is being read |
| st_flag | output | 1 | Self-test status flag |
| sat_flag | output | 1 | Saturation status flag, sticky |
| data_ok | output | 1 | Acceleration data valid, low while SAT is set |

## Verification
The hardest state to reach from the ports is ST held by both causes at once. In that state a status read must remove only the alarm cause, and the flag must still read 1 until a passing checksum arrives. The stimulus gets there in steps. It first fails a checksum. It then pulses an alarm. Next it reads while the alarm is low and checks that ST is still set. Finally it sends a passing checksum and checks that ST drops. The limit boundaries (2270, 2271, 4540, 4541, -32768) and reads that coincide with a set are each driven as their own directed cycles.

// File: rtl/accel_flags_pkg.sv
package accel_flags_pkg;
  localparam int unsigned NUM_AXES = 3;
  typedef logic [NUM_AXES-1:0] axis_mask_t;
endpackage

// File: rtl/afm_rst_sync.sv
module afm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/afm_axis_limit.sv
module afm_axis_limit #(
  parameter int SMP_W = 16,
  parameter int LIMIT = 2270
) (
  input  logic signed [SMP_W-1:0] smp,
  output logic                    over
);
  localparam logic [SMP_W:0] LIM_V = LIMIT[SMP_W:0];

  logic [SMP_W:0] ext;
  logic [SMP_W:0] mag;

  always_comb begin
    ext  = {smp[SMP_W-1], smp};
    mag  = smp[SMP_W-1] ? (~ext + 1'b1) : ext;
    over = (mag > LIM_V);
  end
endmodule

// File: rtl/afm_st_tracker.sv
module afm_st_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_done,
  input  logic chk_pass,
  input  logic alarm_any,
  input  logic status_rd,
  output logic chk_cause,
  output logic alm_cause
);
  logic chk_d, chk_en, chk_q;
  logic alm_d, alm_en, alm_q;

  always_comb begin
    chk_en = chk_done;
    chk_d  = ~chk_pass;
    alm_en = alarm_any | status_rd;
    alm_d  = alarm_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= 1'b0;
      alm_q <= 1'b0;
    end else begin
      if (chk_en) chk_q <= chk_d;
      if (alm_en) alm_q <= alm_d;
    end
  end

  assign chk_cause = chk_q;
  assign alm_cause = alm_q;
endmodule

// File: rtl/afm_sat_tracker.sv
module afm_sat_tracker
  import accel_flags_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  axis_mask_t axis_over,
  input  logic       status_rd,
  output logic       sat_hit,
  output logic       sat_q
);
  logic sat_d, sat_en;

  always_comb begin
    sat_hit = smp_valid & (|axis_over);
    sat_en  = sat_hit | status_rd;
    sat_d   = sat_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q <= 1'b0;
    end else if (sat_en) begin
      sat_q <= sat_d;
    end
  end
endmodule

// File: rtl/accel_status_flags.sv
module accel_status_flags
  import accel_flags_pkg::*;
#(
  parameter int SMP_W      = 16,
  parameter int LIM_NARROW = 2270,
  parameter int LIM_WIDE   = 4540,
  parameter int WIDE_AXIS  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_x,
  input  logic signed [SMP_W-1:0] smp_y,
  input  logic signed [SMP_W-1:0] smp_z,
  input  logic                    chk_done,
  input  logic                    chk_pass,
  input  logic                    alarm_cont,
  input  logic                    alarm_static,
  input  logic                    status_rd,
  output logic                    st_flag,
  output logic                    sat_flag,
  output logic                    data_ok
);
  logic                    rst_sync_n;
  logic signed [SMP_W-1:0] smp_arr [NUM_AXES];
  axis_mask_t              axis_over;
  logic                    alarm_any;
  logic                    chk_cause;
  logic                    alm_cause;
  logic                    sat_hit;
  logic                    sat_q;

  afm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign smp_arr[0] = smp_x;
  assign smp_arr[1] = smp_y;
  assign smp_arr[2] = smp_z;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    localparam int AX_LIMIT = (a == WIDE_AXIS) ? LIM_WIDE : LIM_NARROW;
    afm_axis_limit #(
      .SMP_W (SMP_W),
      .LIMIT (AX_LIMIT)
    ) u_lim (
      .smp  (smp_arr[a]),
      .over (axis_over[a])
    );
  end

  assign alarm_any = alarm_cont | alarm_static;

  afm_st_tracker u_st (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .chk_done  (chk_done),
    .chk_pass  (chk_pass),
    .alarm_any (alarm_any),
    .status_rd (status_rd),
    .chk_cause (chk_cause),
    .alm_cause (alm_cause)
  );

  afm_sat_tracker u_sat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .smp_valid (smp_valid),
    .axis_over (axis_over),
    .status_rd (status_rd),
    .sat_hit   (sat_hit),
    .sat_q     (sat_q)
  );

  assign st_flag  = chk_cause | alm_cause;
  assign sat_flag = sat_q;
  assign data_ok  = ~sat_q;
endmodule

// File: rtl/accel_status_flags_chk.sv
module accel_status_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic chk_done,
  input logic chk_pass,
  input logic alarm_any,
  input logic status_rd,
  input logic sat_hit,
  input logic chk_cause,
  input logic alm_cause,
  input logic st_flag,
  input logic sat_flag
);
  p_chkfail_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_done && !chk_pass) |=> (chk_cause && st_flag));

  p_chk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_cause && !chk_done) |=> chk_cause);

  p_chk_pass_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_done && chk_pass) |=> !chk_cause);

  p_alarm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_any |=> (alm_cause && st_flag));

  p_alarm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_cause && !status_rd) |=> alm_cause);

  p_sat_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |=> sat_flag);

  p_sat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !status_rd) |=> sat_flag);

  p_sat_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !sat_hit) |=> !sat_flag);
endmodule

bind accel_status_flags accel_status_flags_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .chk_done  (chk_done),
  .chk_pass  (chk_pass),
  .alarm_any (alarm_any),
  .status_rd (status_rd),
  .sat_hit   (sat_hit),
  .chk_cause (chk_cause),
  .alm_cause (alm_cause),
  .st_flag   (st_flag),
  .sat_flag  (sat_flag)
);

// File: tb/accel_status_flags_test.sv
`timescale 1ns/1ps
module accel_status_flags_test;
  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid;
  logic signed [15:0] smp_x, smp_y, smp_z;
  logic chk_done, chk_pass, alarm_cont, alarm_static, status_rd;
  logic st_flag, sat_flag, data_ok;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  accel_status_flags uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .chk_done(chk_done), .chk_pass(chk_pass),
    .alarm_cont(alarm_cont), .alarm_static(alarm_static),
    .status_rd(status_rd), .st_flag(st_flag),
    .sat_flag(sat_flag), .data_ok(data_ok)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic check_sat(input logic exp, input string req, input string what);
    check(sat_flag, exp, req, what);
    check(data_ok, ~exp, "R9", what);
  endtask

  task automatic idle_inputs();
    smp_valid = 0; smp_x = 0; smp_y = 0; smp_z = 0;
    chk_done = 0; chk_pass = 0; status_rd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic sample(input int x, input int y, input int z, input logic rd);
    smp_valid = 1; smp_x = 16'(x); smp_y = 16'(y); smp_z = 16'(z); status_rd = rd;
    step();
  endtask

  task automatic chk_result(input logic pass);
    chk_done = 1; chk_pass = pass;
    step();
  endtask

  task automatic rd();
    status_rd = 1;
    step();
  endtask

  task automatic t_reset();
    rst_n = 0; alarm_cont = 0; alarm_static = 0; idle_inputs();
    repeat (3) @(negedge clk);
    check(st_flag, 0, "R1", "st in reset");
    check_sat(0, "R1", "sat in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(st_flag, 0, "R1", "st after release");
    check_sat(0, "R1", "sat after release");
  endtask

  task automatic t_checksum();
    chk_result(0);
    check(st_flag, 1, "R2", "st after checksum fail");
    rd();
    check(st_flag, 1, "R3", "read must not clear checksum cause");
    step();
    check(st_flag, 1, "R3", "checksum cause held");
    chk_result(1);
    check(st_flag, 0, "R3", "passing checksum clears");
  endtask

  task automatic t_alarm();
    alarm_cont = 1;
    step();
    check(st_flag, 1, "R4", "continuous alarm sets");
    rd();
    check(st_flag, 1, "R8", "read while alarm active");
    alarm_cont = 0;
    step();
    check(st_flag, 1, "R4", "alarm cause latched after drop");
    rd();
    check(st_flag, 0, "R4", "read clears alarm cause");
    alarm_static = 1;
    step();
    alarm_static = 0;
    check(st_flag, 1, "R4", "static alarm sets");
    chk_result(1);
    check(st_flag, 1, "R3", "passing checksum leaves alarm cause");
    rd();
    check(st_flag, 0, "R4", "read clears static cause");
  endtask

  task automatic t_both_causes();
    chk_result(0);
    alarm_static = 1;
    step();
    alarm_static = 0;
    rd();
    check(st_flag, 1, "R3", "read with both causes keeps st");
    chk_result(1);
    check(st_flag, 0, "R3", "pass after read clears both");
  endtask

  task automatic t_sat_xy();
    sample(2270, -2270, 0, 0);
    check_sat(0, "R5", "exactly 2270 on x/y");
    sample(2271, 0, 0, 0);
    check_sat(1, "R5", "x 2271");
    step(); step();
    check_sat(1, "R7", "sticky after excess ends");
    rd();
    check_sat(0, "R7", "read clears sat");
    sample(0, -2271, 0, 0);
    check_sat(1, "R5", "y -2271");
    rd();
    check_sat(0, "R7", "read clears sat again");
  endtask

  task automatic t_sat_z();
    sample(0, 0, 4540, 0);
    check_sat(0, "R6", "z exactly 4540");
    sample(0, 0, -3000, 0);
    check_sat(0, "R6", "z -3000 under wide limit");
    sample(0, 0, 4541, 0);
    check_sat(1, "R6", "z 4541");
    rd();
    check_sat(0, "R7", "clear after z");
    sample(0, 0, -32768, 0);
    check_sat(1, "R6", "z -32768");
    rd();
    check_sat(0, "R7", "clear after min");
  endtask

  task automatic t_gate();
    smp_valid = 0; smp_x = 16'sd30000; smp_y = -16'sd30000; smp_z = 16'sd30000;
    @(negedge clk);
    check_sat(0, "R10", "excess ignored without valid");
    idle_inputs();
  endtask

  task automatic t_set_wins();
    sample(5000, 0, 0, 0);
    sample(0, 3000, 0, 1);
    check_sat(1, "R8", "sat set with read same cycle");
    rd();
    check_sat(0, "R7", "clear after set-wins");
    alarm_cont = 1;
    rd();
    alarm_cont = 0;
    check(st_flag, 1, "R8", "alarm set with read same cycle");
    rd();
    check(st_flag, 0, "R4", "final clear");
  endtask

  initial begin
    t_reset();
    t_checksum();
    t_alarm();
    t_both_causes();
    t_sat_xy();
    t_sat_z();
    t_gate();
    t_set_wins();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule